// File: doc/BRIEF.md
# Serial Codec Frame Sequencer

This block sits on the receive end of a codec's synchronous serial data input. It counts bits with a one-cycle shift tick from the system clock. While a host-driven frame level is high it takes in 16-bit words, most significant bit first. Each completed primary word is split in two. The upper fourteen bits go to a DAC sample register. The lowest two bits form a timing command that a period-control unit downstream acts on.

One command value asks for a configuration exchange. After the primary word ends, the block holds its own secondary frame strobe inactive for a fixed number of shift ticks. It then drives that strobe for one 16-tick word, which it delivers as a configuration word. Throughout this exchange it ignores the host frame level and keeps the receive-side frame strobe inactive. The exchange therefore sits between two primary words and never takes the place of a DAC update.

Top module: `serial_frame_seq`

## Requirements
- R1: A primary word is 16 shift ticks taken MSB first while `frame_in` is high. In the clock cycle after the tick that carries the 16th bit, `dac_data` holds word bits 15:2 and `dac_valid` is high for exactly one cycle. `dac_valid` is raised at no other time.
- R2: `ctl_code` carries word bits 1:0, with `ctl_valid` high in the same cycle as `dac_valid`. The encoding is 2'b00 normal period, 2'b01 lengthen the next period, 2'b10 shorten the next period, and 2'b11 run a secondary frame.
- R3: If a shift tick finds `frame_in` low before the 16th bit, the bits collected so far are dropped and the bit count returns to zero. The next complete word is then captured unaltered.
- R4: After a primary word with code 2'b11, `sec_frame_n` stays high through the completion tick and the next 3 shift ticks. It goes low after the 4th shift tick that follows completion (GAP_TICKS = 4).
- R5: Once `sec_frame_n` is low, the next 16 shift ticks form a secondary word, taken MSB first. That word appears on `cfg_word` with a one-cycle `cfg_valid` in the cycle after the 16th tick, and `sec_frame_n` returns high at that point. A secondary word never raises `dac_valid` and never changes `dac_data`.
- R6: `rx_fs_n` is low (active) only when `sync_mode` is 1, `frame_in` is high, and no secondary exchange (gap or secondary word) is in progress. When `sync_mode` is 0 it stays high.
- R7: During the gap and the secondary word, `frame_in` has no effect. It neither ends nor shortens the secondary word, and it produces no primary capture.
- R8: While `rst_n` is low and after its release, both valid strobes are low and `sec_frame_n` is high.
- R9: After a secondary word completes, the next primary word is accepted and decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shift_en | input | 1 | One-cycle shift tick, one per serial bit |
| frame_in | input | 1 | Host primary frame level, high while a word is sent |
| sdata_in | input | 1 | Serial data bit, sampled on a shift tick |
| sync_mode | input | 1 | 1 selects synchronous mode for the receive frame strobe |
| sec_frame_n | output | 1 | Active-low secondary frame strobe generated by the block |
| rx_fs_n | output | 1 | Active-low receive frame strobe |
| dac_data | output | 14 | Last primary sample |
| dac_valid | output | 1 | One-cycle strobe for a new sample |
| ctl_code | output | 2 | Last primary control code |
| ctl_valid | output | 1 | One-cycle strobe for a new control code |
| cfg_word | output | 16 | Last secondary configuration word |
| cfg_valid | output | 1 | One-cycle strobe for a new configuration word |

## Verification
A bit counter left off by one after an aborted frame shows up at the next completed word. The word arrives shifted, and its sample or code is wrong at the `dac_valid` that follows. A sequencer stuck in, or skipping, the gap or secondary state shows within a few shift ticks. `sec_frame_n` falls early or late, `rx_fs_n` goes active during the exchange, or a configuration word is reported as a DAC sample. Random words with all four codes mixed with aborted prefixes exercise every state transition many times.

// File: rtl/scfs_pkg.sv
package scfs_pkg;
  typedef enum logic [1:0] {
    ST_PRIM = 2'd0,
    ST_GAP  = 2'd1,
    ST_SEC  = 2'd2
  } seq_state_t;

  localparam logic [1:0] CODE_NORMAL    = 2'b00;
  localparam logic [1:0] CODE_LENGTHEN  = 2'b01;
  localparam logic [1:0] CODE_SHORTEN   = 2'b10;
  localparam logic [1:0] CODE_SECONDARY = 2'b11;
endpackage

// File: rtl/scfs_shreg.sv
module scfs_shreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              clear,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign last_o = (cnt_q == CNT_W'(WORD_W - 1));
  assign word_o = {sr_q[WORD_W-2:0], bit_in};

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (shift) begin
      sr_d  = word_o;
      cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/scfs_seq.sv
module scfs_seq
  import scfs_pkg::*;
#(
  parameter int GAP_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       prim_done,
  input  logic       sec_done,
  input  logic [1:0] code,
  output seq_state_t state_o
);
  localparam int GCW = $clog2(GAP_TICKS + 1);

  seq_state_t     st_q, st_d;
  logic [GCW-1:0] gcnt_q, gcnt_d;

  assign state_o = st_q;

  always_comb begin
    st_d   = st_q;
    gcnt_d = gcnt_q;
    case (st_q)
      ST_PRIM: begin
        if (prim_done && (code == CODE_SECONDARY)) begin
          st_d   = ST_GAP;
          gcnt_d = '0;
        end
      end
      ST_GAP: begin
        if (shift_en) begin
          if (gcnt_q == GCW'(GAP_TICKS - 1)) st_d = ST_SEC;
          else gcnt_d = gcnt_q + 1'b1;
        end
      end
      ST_SEC: begin
        if (sec_done) st_d = ST_PRIM;
      end
      default: st_d = ST_PRIM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PRIM;
      gcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      gcnt_q <= gcnt_d;
    end
  end
endmodule

// File: rtl/serial_frame_seq.sv
module serial_frame_seq
  import scfs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CODE_W    = 2,
  parameter int GAP_TICKS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic                       frame_in,
  input  logic                       sdata_in,
  input  logic                       sync_mode,
  output logic                       sec_frame_n,
  output logic                       rx_fs_n,
  output logic [WORD_W-CODE_W-1:0]   dac_data,
  output logic                       dac_valid,
  output logic [CODE_W-1:0]          ctl_code,
  output logic                       ctl_valid,
  output logic [WORD_W-1:0]          cfg_word,
  output logic                       cfg_valid
);
  localparam int SAMP_W = WORD_W - CODE_W;

  seq_state_t        state;
  logic              in_prim, in_sec;
  logic              sh_shift, sh_clear, sh_last;
  logic              prim_done, sec_done;
  logic [WORD_W-1:0] word;

  assign in_prim   = (state == ST_PRIM);
  assign in_sec    = (state == ST_SEC);
  assign sh_shift  = shift_en & ((in_prim & frame_in) | in_sec);
  assign sh_clear  = shift_en & in_prim & ~frame_in;
  assign prim_done = sh_shift & in_prim & sh_last;
  assign sec_done  = sh_shift & in_sec & sh_last;

  scfs_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (sh_shift),
    .clear  (sh_clear),
    .bit_in (sdata_in),
    .word_o (word),
    .last_o (sh_last)
  );

  scfs_seq #(.GAP_TICKS(GAP_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .prim_done (prim_done),
    .sec_done  (sec_done),
    .code      (word[CODE_W-1:0]),
    .state_o   (state)
  );

  assign sec_frame_n = ~in_sec;
  assign rx_fs_n     = ~(sync_mode & frame_in & in_prim);

  logic [SAMP_W-1:0] dac_d;
  logic [CODE_W-1:0] code_d;
  logic [WORD_W-1:0] cfg_d;

  always_comb begin
    dac_d  = dac_data;
    code_d = ctl_code;
    cfg_d  = cfg_word;
    if (prim_done) begin
      dac_d  = word[WORD_W-1:CODE_W];
      code_d = word[CODE_W-1:0];
    end
    if (sec_done) cfg_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_data  <= '0;
      ctl_code  <= '0;
      cfg_word  <= '0;
      dac_valid <= 1'b0;
      ctl_valid <= 1'b0;
      cfg_valid <= 1'b0;
    end else begin
      dac_data  <= dac_d;
      ctl_code  <= code_d;
      cfg_word  <= cfg_d;
      dac_valid <= prim_done;
      ctl_valid <= prim_done;
      cfg_valid <= sec_done;
    end
  end
endmodule

// File: rtl/scfs_chk.sv
module scfs_chk #(
  parameter int WORD_W    = 16,
  parameter int GAP_TICKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shift_en,
  input logic       sync_mode,
  input logic       sec_frame_n,
  input logic       rx_fs_n,
  input logic       dac_valid,
  input logic       ctl_valid,
  input logic [1:0] ctl_code,
  input logic       cfg_valid
);
  logic [7:0] gap_cnt;
  logic [7:0] sec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      sec_cnt <= '0;
    end else begin
      if (ctl_valid && ctl_code == 2'b11) gap_cnt <= shift_en ? 8'd1 : 8'd0;
      else if (shift_en && sec_frame_n && gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
      if (sec_frame_n) sec_cnt <= '0;
      else if (shift_en) sec_cnt <= sec_cnt + 8'd1;
    end
  end

  assert_dac_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  assert_code_with_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> ctl_valid);
  assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_frame_n) |-> gap_cnt == 8'(GAP_TICKS));
  assert_sec_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_frame_n) |-> sec_cnt == 8'(WORD_W));
  assert_cfg_in_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(!sec_frame_n));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dac_valid, cfg_valid}));
  assert_rx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_frame_n || !sync_mode) |-> rx_fs_n);
  assert_no_dac_in_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_frame_n |-> !dac_valid);
endmodule

bind serial_frame_seq scfs_chk #(.WORD_W(WORD_W), .GAP_TICKS(GAP_TICKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shift_en    (shift_en),
  .sync_mode   (sync_mode),
  .sec_frame_n (sec_frame_n),
  .rx_fs_n     (rx_fs_n),
  .dac_valid   (dac_valid),
  .ctl_valid   (ctl_valid),
  .ctl_code    (ctl_code),
  .cfg_valid   (cfg_valid)
);

// File: tb/test_serial_frame_seq.sv
module test_serial_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        shift_en, frame_in, sdata_in, sync_mode;
  logic        sec_frame_n, rx_fs_n;
  logic [13:0] dac_data;
  logic        dac_valid, ctl_valid, cfg_valid;
  logic [1:0]  ctl_code;
  logic [15:0] cfg_word;

  int n_cmp = 0, n_bad = 0;
  int n_dac = 0, n_ctl = 0, n_cfg = 0;
  logic rx_seen;

  always #4 clk = ~clk;

  serial_frame_seq i_serial_frame_seq (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .frame_in(frame_in),
    .sdata_in(sdata_in), .sync_mode(sync_mode), .sec_frame_n(sec_frame_n),
    .rx_fs_n(rx_fs_n), .dac_data(dac_data), .dac_valid(dac_valid),
    .ctl_code(ctl_code), .ctl_valid(ctl_valid), .cfg_word(cfg_word),
    .cfg_valid(cfg_valid)
  );

  always @(negedge clk) begin
    if (dac_valid) n_dac++;
    if (ctl_valid) n_ctl++;
    if (cfg_valid) n_cfg++;
  end

  function automatic logic [13:0] exp_sample(input logic [15:0] w);
    return w[15:2];
  endfunction
  function automatic logic [1:0] exp_code(input logic [15:0] w);
    return w[1:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b, input logic fr);
    @(negedge clk);
    shift_en = 1'b1; sdata_in = b; frame_in = fr;
    #1 rx_seen = rx_fs_n;
    @(negedge clk);
    shift_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_counts();
    n_dac = 0; n_ctl = 0; n_cfg = 0;
  endtask

  task automatic send_primary(input logic [15:0] w);
    logic rx_ok = 1'b1;
    clr_counts();
    for (int i = 15; i >= 0; i--) begin
      tick(w[i], 1'b1);
      if (rx_seen !== ~sync_mode) rx_ok = 1'b0;
    end
    check("R1 dac pulses", n_dac, 1);
    check("R1 dac_data", dac_data, exp_sample(w));
    check("R2 ctl pulses", n_ctl, 1);
    check("R2 ctl_code", ctl_code, exp_code(w));
    check("R6 rx_fs_n in primary", rx_ok, 1);
  endtask

  task automatic run_secondary(input logic [15:0] c, input logic host_fr);
    logic [13:0] dac_before = dac_data;
    logic rx_ok = 1'b1;
    check("R4 sec_frame_n after completion", sec_frame_n, 1);
    for (int g = 1; g <= 4; g++) begin
      tick(1'b0, host_fr);
      check("R4 sec_frame_n gap", sec_frame_n, (g == 4) ? 0 : 1);
    end
    clr_counts();
    for (int i = 15; i >= 0; i--) begin
      tick(c[i], host_fr);
      if (rx_seen !== 1'b1) rx_ok = 1'b0;
      if (i > 0 && sec_frame_n !== 1'b0) rx_ok = 1'b0;
    end
    check("R5 cfg pulses", n_cfg, 1);
    check("R5 cfg_word", cfg_word, c);
    check("R5 no dac pulse", n_dac, 0);
    check("R5 dac_data kept", dac_data, dac_before);
    check("R5 sec_frame_n released", sec_frame_n, 1);
    check("R7 rx quiet and frame length", rx_ok, 1);
  endtask

  task automatic idle_tick();
    tick(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; shift_en = 1'b0; frame_in = 1'b0; sdata_in = 1'b0; sync_mode = 1'b1;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R8 reset sec_frame_n", sec_frame_n, 1);
    check("R8 reset dac_valid", dac_valid, 0);
    check("R8 reset cfg_valid", cfg_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 after release valids", {dac_valid, ctl_valid, cfg_valid}, 0);
    check("R8 after release sec_frame_n", sec_frame_n, 1);

    // directed: each code value
    send_primary(16'hA5A4); idle_tick();   // R2 code 00
    send_primary(16'h1235); idle_tick();   // R2 code 01
    send_primary(16'hFFFE); idle_tick();   // R2 code 10
    send_primary(16'h8003);                // R2 code 11
    run_secondary(16'hC33C, 1'b1);         // R7 host frame held high
    send_primary(16'h4C70); idle_tick();   // R9
    check("R9 code after secondary", ctl_code, 2'b00);

    // R3: aborted prefix then full word
    clr_counts();
    for (int i = 0; i < 9; i++) tick(1'b1, 1'b1);
    idle_tick();
    check("R3 no pulse on partial", n_dac, 0);
    send_primary(16'h0F0C); idle_tick();

    // R6: async mode keeps rx_fs_n high
    sync_mode = 1'b0;
    send_primary(16'h2468); idle_tick();
    sync_mode = 1'b1;

    // random words and prefixes
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w = 16'($urandom);
      if ($urandom_range(3, 0) == 0) begin
        int plen = $urandom_range(15, 1);
        clr_counts();
        for (int i = 0; i < plen; i++) tick(1'($urandom), 1'b1);
        idle_tick();
        check("R3 random partial", n_dac, 0);
      end
      send_primary(w);
      if (w[1:0] == 2'b11) run_secondary(16'($urandom), 1'($urandom));
      if ($urandom_range(1, 0) == 1) idle_tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule